// File: doc/BRIEF.md
# Serial Control/Status Shift Interface

This block is a serial slave framed by an active-low select. It takes in a control word one bit at a time and returns a status word on a shared return line, with the least significant bit first in both directions. A complete control word is moved into a parallel control register only when its frame ends. The block presents that register to the switch and protection logic. In the other direction it takes a parallel status word from that logic and shifts it out.

All serial pins are oversampled by one fast system clock. Each pin passes through a synchroniser and an edge detector. Select, serial clock and data therefore reach the logic with the same latency.

A frame with too few bits commits nothing. A word that carries the reserved test code in its two top bits is discarded. Clocking more bits than one word holds turns the block into a pass-through stage, so several devices can be chained on one loop. The output enable lets several devices share one return line.

Top module: `ser_ctl_link`

## Requirements
- R1: After reset, `ctrl_o` is 16'h2000, with only bit 13 set. `sdo_oe_o` is low.
- R2: `sdo_oe_o` is high only while select is low. When it is low, `sdo_o` is 0.
- R3: Input bits are sampled on falling serial clock edges within a frame. On the select rise, `ctrl_o` takes the last 16 bits received. The earliest of those bits goes to bit 0.
- R4: The status word is captured at the start of the frame. Bit 0 appears on `sdo_o` before any serial clock edge. The line moves to the next bit on each rising serial clock edge that follows a falling edge.
- R5: A change of `stat_i` during a frame does not change the bits shifted out in that frame.
- R6: A frame ended with fewer than 16 falling serial clock edges leaves `ctrl_o` unchanged.
- R7: A word with bit 15 and bit 14 both high is discarded, and `ctrl_o` keeps its old value. A word with only one of those two bits set is accepted.
- R8: After the 16 status bits, `sdo_o` presents the input bits received in the same frame, in their order of arrival. This lets devices be chained.
- R9: Serial clock and data activity while select is high has no effect on `ctrl_o`. It also does not count toward the next frame.
- R10: Layout of `ctrl_o`:
  - bit 0: status clear
  - bits 1 to 6: low and high switches of channels 1, 2 and 3, in the order low1, high1, low2, high2, low3, high3
  - bit 13: overcurrent shutdown enable
  - all other bits: unused

  The bits are passed to the protection logic unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low frame select |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in, LSB first |
| stat_i | input | 16 | Parallel status word from the protection logic |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the shared return line |
| ctrl_o | output | 16 | Committed control word |

## Verification
Several rules are checked on every cycle:
- the control register changes only one cycle after a select rise;
- it never takes a word that carries the test code;
- the transmit register holds still within a frame except on a shift;
- the receive state is frozen outside a frame.

Other behaviour needs full frames to show, and only the bench scenarios cover it. This includes the status bit order on the line and bit 0 being present with no clock at all. It also covers which 16 bits are kept from a long frame, the pass-through of input bits in a chain, and short or idle-clocked frames leaving the register alone.

// File: rtl/ser_link_pkg.sv
package ser_link_pkg;
  localparam int unsigned DEF_WORD_W = 16;
  localparam int unsigned DEF_OCS_BIT = 13;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/sl_sync_edge.sv
module sl_sync_edge
  import ser_link_pkg::*;
#(
  parameter int unsigned STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  in_i,
  output edge_t ev_o
);
  logic [STAGES-1:0] s_q;
  logic d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q <= {STAGES{RST_VAL}};
      d_q <= RST_VAL;
    end else begin
      s_q <= {s_q[STAGES-2:0], in_i};
      d_q <= s_q[STAGES-1];
    end
  end

  assign ev_o.lvl  = s_q[STAGES-1];
  assign ev_o.rise = s_q[STAGES-1] & ~d_q;
  assign ev_o.fall = ~s_q[STAGES-1] & d_q;
endmodule

// File: rtl/sl_rx.sv
module sl_rx #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              smp_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (!frame_i) begin
      cnt_q <= '0;
    end else if (smp_i) begin
      sh_q <= {bit_i, sh_q[WORD_W-1:1]};
      if (cnt_q != CNT_W'(WORD_W)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word_o = sh_q;
  assign full_o = (cnt_q == CNT_W'(WORD_W));

  // R9
  idle_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_i && cnt_q == '0) |=> ($stable(sh_q) && cnt_q == '0));
  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(WORD_W));
endmodule

// File: rtl/sl_tx.sv
module sl_tx #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              mark_i,
  input  logic              shift_i,
  input  logic              fill_i,
  input  logic [WORD_W-1:0] stat_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] tx_q;
  logic pend_q, fill_q;
  logic do_shift;

  assign do_shift = shift_i & pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      pend_q <= 1'b0;
      fill_q <= 1'b0;
    end else if (!frame_i) begin
      tx_q   <= stat_i;  // snapshot frozen at frame start
      pend_q <= 1'b0;
    end else begin
      if (mark_i) begin
        pend_q <= 1'b1;
        fill_q <= fill_i;
      end
      if (do_shift) begin
        tx_q   <= {fill_q, tx_q[WORD_W-1:1]};
        pend_q <= 1'b0;
      end
    end
  end

  assign bit_o = tx_q[0];

  // R5
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !do_shift) |=> $stable(tx_q));
endmodule

// File: rtl/ser_ctl_link.sv
module ser_ctl_link
  import ser_link_pkg::*;
#(
  parameter int unsigned WORD_W      = DEF_WORD_W,
  parameter int unsigned OCS_BIT     = DEF_OCS_BIT,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [WORD_W-1:0] stat_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [WORD_W-1:0] ctrl_o
);
  localparam logic [WORD_W-1:0] RST_WORD = WORD_W'(1) << OCS_BIT;
  localparam int unsigned TEST_HI = WORD_W - 1;
  localparam int unsigned TEST_LO = WORD_W - 2;
  localparam int unsigned N_PINS = 3;
  localparam logic [N_PINS-1:0] PIN_RST = 3'b001;

  logic [N_PINS-1:0] pins;
  edge_t ev [N_PINS];

  assign pins = {sdi_i, sclk_i, cs_ni};

  for (genvar g = 0; g < N_PINS; g++) begin : g_sync
    sl_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_RST[g])) i_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  (pins[g]),
      .ev_o  (ev[g])
    );
  end

  logic frame, frame_end;
  logic [WORD_W-1:0] rx_word;
  logic rx_full, tx_bit, test_pat;
  logic [WORD_W-1:0] ctrl_q;

  assign frame     = ~ev[0].lvl;
  assign frame_end = ev[0].rise;

  sl_rx #(.WORD_W(WORD_W)) i_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .frame_i(frame),
    .smp_i  (ev[1].fall),
    .bit_i  (ev[2].lvl),
    .word_o (rx_word),
    .full_o (rx_full)
  );

  sl_tx #(.WORD_W(WORD_W)) i_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .frame_i(frame),
    .mark_i (ev[1].fall),
    .shift_i(ev[1].rise),
    .fill_i (ev[2].lvl),
    .stat_i (stat_i),
    .bit_o  (tx_bit)
  );

  assign test_pat = rx_word[TEST_HI] & rx_word[TEST_LO];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= RST_WORD;
    else if (frame_end && rx_full && !test_pat) ctrl_q <= rx_word;
  end

  assign ctrl_o   = ctrl_q;
  assign sdo_oe_o = frame;
  assign sdo_o    = frame & tx_bit;

  // R6
  commit_on_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_q) |-> $past(frame_end));
  // R7
  no_test_pat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_q) |-> !(ctrl_q[TEST_HI] && ctrl_q[TEST_LO]));
  // R2
  quiet_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3) |-> !sdo_oe_o);
endmodule

// File: tb/test_ser_ctl_link.sv
module test_ser_ctl_link;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [15:0] stat = '0;
  logic sdo, sdo_oe;
  logic [15:0] ctrl;

  int n_chk = 0, n_fail = 0;
  logic [15:0] model_ctrl = 16'h2000;
  logic [15:0] exp_q[$];
  event frame_ev;

  always #10 clk = ~clk;

  ser_ctl_link i_ser_ctl_link (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk), .sdi_i(sdi),
    .stat_i(stat), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .ctrl_o(ctrl)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: runs one frame, checks the return line, queues the expected word
  task automatic frame(logic [31:0] din, int nbits, logic [15:0] st_mid, string req);
    logic [15:0] st0;
    logic [15:0] w;
    st0 = stat;
    cs_ni = 1'b0;
    wclk(8);
    check({req, " R2 oe in frame"}, sdo_oe, 1);
    check({req, " R4 bit0 before clock"}, sdo, st0[0]);
    stat = st_mid;
    for (int i = 0; i < nbits; i++) begin
      sdi = din[i];
      sclk = 1'b1;
      wclk(8);
      if (i < 16) check({req, " R4/R5 status bit"}, sdo, st0[i]);
      else check({req, " R8 chain bit"}, sdo, din[i-16]);
      sclk = 1'b0;
      wclk(8);
    end
    cs_ni = 1'b1;
    if (nbits >= 16) begin
      w = din[nbits-16 +: 16];
      if (!(w[15] && w[14])) model_ctrl = w;
    end
    exp_q.push_back(model_ctrl);
    -> frame_ev;
    wclk(14);
    check({req, " R2 oe idle"}, {sdo_oe, sdo}, 2'b00);
  endtask

  // monitor
  initial begin
    forever begin
      @(frame_ev);
      wclk(8);
      check("R3/R6/R7 ctrl", ctrl, exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    wclk(3);
    rst_ni = 1'b1;
    wclk(3);
    check("R1 reset ctrl", ctrl, 16'h2000);
    check("R1 reset oe", sdo_oe, 0);
    stat = 16'hA5C3;
    frame(32'h007E, 16, 16'h5A3C, "R3 R10 all switches");
    check("R10 switch field", ctrl[6:1], 6'h3F);
    stat = 16'h1234;
    frame(32'h2055, 16, 16'h1234, "R3 ocs plus mix");
    check("R10 ocs bit", ctrl[13], 1);
    stat = 16'hFFFF;
    frame(32'h00FF, 8, 16'h0000, "R6 short");
    stat = 16'h0001;
    cs_ni = 1'b0;
    wclk(8);
    check("R4 TP read no clock", sdo, 1);
    cs_ni = 1'b1;
    wclk(10);
    check("R6 TP read no commit", ctrl, 16'h2055);
    for (int k = 0; k < 20; k++) begin
      sdi = k[0];
      sclk = ~sclk;
      wclk(6);
    end
    sclk = 1'b0;
    wclk(6);
    check("R9 idle clocks", ctrl, 16'h2055);
    stat = 16'h8001;
    frame(32'h0000_C00A, 16, 16'h8001, "R7 test pattern");
    frame(32'h0000_800A, 16, 16'h8001, "R7 single top bit");
    stat = 16'h3C5A;
    frame(32'h00_6D_0024, 24, 16'h0000, "R8 long frame");
    frame(32'h0000_0003, 16, 16'h0000, "R9 after idle");
    wclk(20);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule